// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applier

This block sits behind a Reed-Solomon decoder whose symbols are 12 bits wide and which protects a 2048-byte data page followed by a small spare area. The decoder produces up to four corrections, each a symbol position and a 12-bit error pattern. The block turns each correction into one or two byte-level XOR updates. It applies those updates with read-modify-write cycles on a byte-wide buffer port. When a correction cannot be applied, it reports the page as uncorrectable.

Symbols are packed across byte boundaries. Every global byte index at or above the data size lands in the spare buffer, at that index minus the data size. Corrections are taken one at a time in list order. Once a correction is found to be unusable, the rest of the list is abandoned. Any updates made before that point stay in the buffer. A single-cycle `done` pulse closes every run and carries the outcome.

Top module: `symfix_apply`

## Requirements
- R1: A position above LAST_POS (1374) raises `fail` and ends the run with no buffer access for that entry or any later one; updates from earlier entries stay in the buffer.
- R2: Position 0 touches only data byte 0, which is XORed with the pattern. If pattern bits 11:8 are non-zero, `fail` is raised and nothing is written for that entry.
- R3: For an odd position p, with g = floor(3p/2), global byte g is XORed with pattern[11:4] and global byte g+1 with {pattern[3:0],4'b0000}.
- R4: For an even position p > 0, with g = floor(3p/2), global byte g-1 is XORed with {4'b0000,pattern[11:8]} and global byte g with pattern[7:0].
- R5: Position 1365 straddles the boundary. Data byte 2047 takes pattern[11:4] and spare byte 0 takes {pattern[3:0],4'b0000}.
- R6: A global byte index g >= 2048 is written to the spare buffer (`mem_spare`=1) at address g-2048.
- R7: Entries are applied in list order. Each byte update is a read (`mem_rd`) followed in the next cycle by a write (`mem_wr`) to the same address, with `mem_wdata` = read data XOR mask. A later entry therefore sees the result of an earlier one.
- R8: `done` is high for exactly one cycle per run. With it, `fail` is 0 and `fixed_cnt` equals the number of entries applied; on failure `fail` is 1 and `fixed_cnt` is 0.
- R9: Counting the edge that samples `start` as edge 1, `done` is high after edge 2 + 5·k + 3·z, where k is the number of two-byte entries applied and z the number of position-0 entries applied.
- R10: A count of 0 produces `done` after edge 2, with no buffer access, `fail`=0 and `fixed_cnt`=0.
- R11: A count above N_CORR is treated as N_CORR.
- R12: `start` while `busy` is ignored: the run in progress completes with its own list.
- R13: After reset `busy`, `done`, `fail`, `mem_rd` and `mem_wr` are 0, and there is no buffer access while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latch the correction list and begin a run (sampled when idle) |
| corr_cnt | input | 3 | Number of valid list entries |
| corr_pos | input | 44 | Symbol positions, entry i at bits [11i+10:11i] |
| corr_pat | input | 48 | Error patterns, entry i at bits [12i+11:12i] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Page uncorrectable (valid with and after `done`) |
| fixed_cnt | output | 3 | Entries applied (valid with and after `done`) |
| mem_rd | output | 1 | Buffer read request, data returned next cycle |
| mem_wr | output | 1 | Buffer write strobe |
| mem_spare | output | 1 | 1 selects the spare buffer, 0 the data buffer |
| mem_addr | output | 11 | Byte address within the selected buffer |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
The bench builds the block with its default parameters: four list slots, a 2048-byte data buffer, a 64-byte spare buffer, and a last valid position of 1374. With these values it can reach the straddling symbol at 1365, the highest valid spare position, the first rejected position, and a list long enough to repeat one position and to be clamped from an oversized count. A behavioural model predicts every buffer write and the exact `done` cycle. The bench compares these predictions with the design on every clock.

// File: rtl/symfix_pkg.sv
// Shared constants and the controller state type for the symbol error applier.
// Assumes 12-bit Reed-Solomon symbols and a byte-wide buffer.
package symfix_pkg;
    localparam int SYM_W  = 12;
    localparam int BYTE_W = 8;
    localparam int PAD_W  = 2 * BYTE_W - SYM_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_HI,
        ST_WR_HI,
        ST_RD_LO,
        ST_WR_LO,
        ST_FIN
    } fix_state_t;
endpackage

// File: rtl/symfix_map.sv
// Combinational locator: turns one symbol position and pattern into two byte
// updates (the upper byte may be disabled) and a reject flag.
// Assumes symbols are packed MSB first, two symbols per three bytes, and that
// the spare buffer follows the data buffer in global byte numbering.
module symfix_map
    import symfix_pkg::*;
#(
    parameter int DATA_BYTES = 2048,
    parameter int LAST_POS   = 1374,
    parameter int POS_W      = 11,
    parameter int ADDR_W     = 11
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [SYM_W-1:0]  pat,
    output logic              hi_en,
    output logic              hi_spare,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [BYTE_W-1:0] hi_mask,
    output logic              lo_en,
    output logic              lo_spare,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [BYTE_W-1:0] lo_mask,
    output logic              bad
);
    localparam int G_W = POS_W + 2;

    logic [G_W-1:0] g_base;
    logic [G_W-1:0] g_hi;
    logic [G_W-1:0] g_lo;
    logic           odd;
    logic           zero;

    // Global byte index floor(3p/2) and the two neighbouring bytes it touches.
    always_comb begin
        g_base = ({2'b00, pos} + {1'b0, pos, 1'b0}) >> 1;
        odd    = pos[0];
        zero   = (pos == '0);
        g_hi   = odd ? g_base : g_base - G_W'(1);
        g_lo   = odd ? g_base + G_W'(1) : g_base;
    end

    // Masks follow the packing: odd symbols start on a byte, even ones end on one.
    always_comb begin
        if (odd) begin
            hi_mask = pat[SYM_W-1:SYM_W-BYTE_W];
            lo_mask = {pat[SYM_W-BYTE_W-1:0], {PAD_W{1'b0}}};
        end else begin
            hi_mask = {{PAD_W{1'b0}}, pat[SYM_W-1:BYTE_W]};
            lo_mask = pat[BYTE_W-1:0];
        end
    end

    // Route each global index to the data or spare buffer.
    always_comb begin
        hi_spare = (g_hi >= G_W'(DATA_BYTES));
        lo_spare = (g_lo >= G_W'(DATA_BYTES));
        hi_addr  = ADDR_W'(hi_spare ? g_hi - G_W'(DATA_BYTES) : g_hi);
        lo_addr  = ADDR_W'(lo_spare ? g_lo - G_W'(DATA_BYTES) : g_lo);
    end

    // The first symbol has no upper byte; out-of-range or over-wide symbols reject.
    always_comb begin
        hi_en = !zero;
        lo_en = 1'b1;
        bad   = (pos > POS_W'(LAST_POS)) ||
                (zero && (pat[SYM_W-1:BYTE_W] != '0));
    end
endmodule

// File: rtl/symfix_list.sv
// Correction list store: captures all entries and the clamped count on load,
// and presents the entry picked by the select index.
// Assumes load happens only while the controller is idle.
module symfix_list
    import symfix_pkg::*;
#(
    parameter int N_CORR = 4,
    parameter int POS_W  = 11,
    parameter int CNT_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [CNT_W-1:0]        cnt_in,
    input  logic [N_CORR*POS_W-1:0] pos_flat,
    input  logic [N_CORR*SYM_W-1:0] pat_flat,
    input  logic [CNT_W-1:0]        sel,
    output logic [POS_W-1:0]        cur_pos,
    output logic [SYM_W-1:0]        cur_pat,
    output logic [CNT_W-1:0]        total
);
    logic [POS_W-1:0] pos_q [N_CORR];
    logic [SYM_W-1:0] pat_q [N_CORR];

    for (genvar i = 0; i < N_CORR; i++) begin : g_slot
        // Capture one list slot at the start of a run.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pos_q[i] <= '0;
                pat_q[i] <= '0;
            end else if (load) begin
                pos_q[i] <= pos_flat[i*POS_W +: POS_W];
                pat_q[i] <= pat_flat[i*SYM_W +: SYM_W];
            end
        end
    end

    // Capture the entry count, clamped to the number of slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (load) begin
            total <= (cnt_in > CNT_W'(N_CORR)) ? CNT_W'(N_CORR) : cnt_in;
        end
    end

    // Present the selected slot.
    always_comb begin
        cur_pos = '0;
        cur_pat = '0;
        for (int i = 0; i < N_CORR; i++) begin
            if (sel == CNT_W'(i)) begin
                cur_pos = pos_q[i];
                cur_pat = pat_q[i];
            end
        end
    end
endmodule

// File: rtl/symfix_fsm.sv
// Run controller: walks the list in order, issues read-then-write pairs for
// each byte update, stops on a rejected entry and pulses done with the outcome.
// Assumes buffer read data arrives one cycle after the read request.
module symfix_fsm
    import symfix_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] total,
    input  logic             bad,
    input  logic             hi_en,
    input  logic             lo_en,
    output logic             load,
    output logic [CNT_W-1:0] sel,
    output logic             busy,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             use_lo,
    output logic             done,
    output logic             fail,
    output logic [CNT_W-1:0] fixed_cnt
);
    fix_state_t state;

    // Sequence the run and keep the outcome registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sel       <= '0;
            fail      <= 1'b0;
            fixed_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sel       <= '0;
                        fail      <= 1'b0;
                        fixed_cnt <= '0;
                        state     <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (sel == total) begin
                        fixed_cnt <= sel;
                        state     <= ST_FIN;
                    end else if (bad) begin
                        fail      <= 1'b1;
                        fixed_cnt <= '0;
                        state     <= ST_FIN;
                    end else if (hi_en) begin
                        state <= ST_RD_HI;
                    end else begin
                        state <= ST_RD_LO;
                    end
                end
                ST_RD_HI: state <= ST_WR_HI;
                ST_WR_HI: begin
                    if (lo_en) begin
                        state <= ST_RD_LO;
                    end else begin
                        sel   <= sel + CNT_W'(1);
                        state <= ST_CHECK;
                    end
                end
                ST_RD_LO: state <= ST_WR_LO;
                ST_WR_LO: begin
                    sel   <= sel + CNT_W'(1);
                    state <= ST_CHECK;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode port strobes and status from the state.
    always_comb begin
        load   = (state == ST_IDLE) && start;
        busy   = (state != ST_IDLE);
        mem_rd = (state == ST_RD_HI) || (state == ST_RD_LO);
        mem_wr = (state == ST_WR_HI) || (state == ST_WR_LO);
        use_lo = (state == ST_RD_LO) || (state == ST_WR_LO);
        done   = (state == ST_FIN);
    end
endmodule

// File: rtl/symfix_apply.sv
// Top of the symbol error applier: list store, locator and controller, with the
// buffer port multiplexed between the two byte updates of the current entry.
// Assumes a buffer with one-cycle read latency and write-through on mem_wr.
module symfix_apply
    import symfix_pkg::*;
#(
    parameter int N_CORR      = 4,
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int LAST_POS    = 1374,
    localparam int POS_W  = $clog2(LAST_POS + 1),
    localparam int CNT_W  = $clog2(N_CORR + 1),
    localparam int ADDR_W = $clog2(DATA_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CNT_W-1:0]        corr_cnt,
    input  logic [N_CORR*POS_W-1:0] corr_pos,
    input  logic [N_CORR*SYM_W-1:0] corr_pat,
    output logic                    busy,
    output logic                    done,
    output logic                    fail,
    output logic [CNT_W-1:0]        fixed_cnt,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic                    mem_spare,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTE_W-1:0]       mem_wdata,
    input  logic [BYTE_W-1:0]       mem_rdata
);
    logic              load;
    logic [CNT_W-1:0]  sel;
    logic [CNT_W-1:0]  total;
    logic [POS_W-1:0]  cur_pos;
    logic [SYM_W-1:0]  cur_pat;
    logic              hi_en, hi_spare, lo_en, lo_spare, bad, use_lo;
    logic [ADDR_W-1:0] hi_addr, lo_addr;
    logic [BYTE_W-1:0] hi_mask, lo_mask, cur_mask;

    symfix_list #(.N_CORR(N_CORR), .POS_W(POS_W), .CNT_W(CNT_W)) u_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cnt_in   (corr_cnt),
        .pos_flat (corr_pos),
        .pat_flat (corr_pat),
        .sel      (sel),
        .cur_pos  (cur_pos),
        .cur_pat  (cur_pat),
        .total    (total)
    );

    symfix_map #(.DATA_BYTES(DATA_BYTES), .LAST_POS(LAST_POS),
                 .POS_W(POS_W), .ADDR_W(ADDR_W)) u_map (
        .pos      (cur_pos),
        .pat      (cur_pat),
        .hi_en    (hi_en),
        .hi_spare (hi_spare),
        .hi_addr  (hi_addr),
        .hi_mask  (hi_mask),
        .lo_en    (lo_en),
        .lo_spare (lo_spare),
        .lo_addr  (lo_addr),
        .lo_mask  (lo_mask),
        .bad      (bad)
    );

    symfix_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .total     (total),
        .bad       (bad),
        .hi_en     (hi_en),
        .lo_en     (lo_en),
        .load      (load),
        .sel       (sel),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .use_lo    (use_lo),
        .done      (done),
        .fail      (fail),
        .fixed_cnt (fixed_cnt)
    );

    // Steer the buffer port to the byte update being worked on.
    always_comb begin
        mem_spare = use_lo ? lo_spare : hi_spare;
        mem_addr  = use_lo ? lo_addr  : hi_addr;
        cur_mask  = use_lo ? lo_mask  : hi_mask;
        mem_wdata = mem_rdata ^ cur_mask;
    end
endmodule

// File: rtl/symfix_apply_chk.sv
// Protocol checker for the symbol error applier, bound to every instance.
// Assumes reset is asserted from time zero.
module symfix_apply_chk #(
    parameter int SPARE_BYTES = 64,
    parameter int ADDR_W      = 11,
    parameter int CNT_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [CNT_W-1:0]  fixed_cnt,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_spare,
    input logic [ADDR_W-1:0] mem_addr
);
    // R7
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    // R7
    wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == $past(mem_addr)) && (mem_spare == $past(mem_spare)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    fail_zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (fixed_cnt == '0));

    // R6
    spare_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && mem_spare) |-> (mem_addr < ADDR_W'(SPARE_BYTES)));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));
endmodule

bind symfix_apply symfix_apply_chk #(
    .SPARE_BYTES (SPARE_BYTES),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fixed_cnt (fixed_cnt),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_spare (mem_spare),
    .mem_addr  (mem_addr)
);

// File: tb/symfix_apply_test.sv
module symfix_apply_test;
    localparam int NC = 4;
    localparam int PW = 11;
    localparam int SW = 12;
    localparam int DB = 2048;
    localparam int SB = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       corr_cnt = '0;
    logic [NC*PW-1:0] corr_pos = '0;
    logic [NC*SW-1:0] corr_pat = '0;
    logic             busy, done, fail, mem_rd, mem_wr, mem_spare;
    logic [2:0]       fixed_cnt;
    logic [10:0]      mem_addr;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata = '0;

    logic [7:0] dmem [DB];
    logic [7:0] smem [SB];
    int exp_d [DB];
    int exp_s [SB];
    int wq [$];
    int checks = 0;
    int fails = 0;
    string cur_tag = "R13";

    always #4 clk = ~clk;

    symfix_apply uut (
        .clk(clk), .rst_n(rst_n), .start(start), .corr_cnt(corr_cnt),
        .corr_pos(corr_pos), .corr_pat(corr_pat), .busy(busy), .done(done),
        .fail(fail), .fixed_cnt(fixed_cnt), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_spare(mem_spare), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Buffer model: one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_spare ? smem[mem_addr[5:0]] : dmem[mem_addr];
        if (mem_wr) begin
            if (mem_spare) smem[mem_addr[5:0]] <= mem_wdata;
            else dmem[mem_addr] <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Per-clock comparison of buffer writes against the model queue (R7).
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            int got;
            got = (int'(mem_spare) << 20) | (int'(mem_addr) << 8) | int'(mem_wdata);
            if (wq.size() == 0) begin
                check(1'b0, cur_tag, "unexpected write", got, 0);
            end else begin
                int e;
                e = wq.pop_front();
                check(got == e, cur_tag, "write spare/addr/data", got, e);
            end
        end
    end

    task automatic model_byte(input int gi, input int m);
        if (gi >= DB) begin
            exp_s[gi-DB] = exp_s[gi-DB] ^ m;
            wq.push_back((1 << 20) | ((gi - DB) << 8) | exp_s[gi-DB]);
        end else begin
            exp_d[gi] = exp_d[gi] ^ m;
            wq.push_back((gi << 8) | exp_d[gi]);
        end
    endtask

    task automatic run_case(input int n, input int p [4], input int q [4],
                            input string tag, input bit poke);
        int eff, lat, applied, seen, g;
        bit efail, got;
        cur_tag = tag;
        eff = (n > NC) ? NC : n;
        lat = 2;
        applied = 0;
        efail = 1'b0;
        for (int i = 0; i < eff; i++) begin
            if (p[i] > 1374) begin efail = 1'b1; break; end
            if (p[i] == 0) begin
                if (q[i] > 255) begin efail = 1'b1; break; end
                model_byte(0, q[i]);
                lat += 3;
            end else begin
                g = (3 * p[i]) / 2;
                if (p[i] % 2 == 1) begin
                    model_byte(g, q[i] >> 4);
                    model_byte(g + 1, (q[i] << 4) & 255);
                end else begin
                    model_byte(g - 1, q[i] >> 8);
                    model_byte(g, q[i] & 255);
                end
                lat += 5;
            end
            applied++;
        end
        @(negedge clk);
        corr_cnt = 3'(n);
        for (int i = 0; i < NC; i++) begin
            corr_pos[i*PW +: PW] = PW'(p[i]);
            corr_pat[i*SW +: SW] = SW'(q[i]);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1;
        got = 1'b0;
        while (!got && seen < 200) begin
            if (done) begin
                got = 1'b1;
                check(seen == lat, "R9", {tag, " done cycle"}, seen, lat);
                check(fail == efail, "R8", {tag, " fail"}, int'(fail), int'(efail));
                check(int'(fixed_cnt) == (efail ? 0 : applied), "R8",
                      {tag, " fixed_cnt"}, int'(fixed_cnt), efail ? 0 : applied);
                check(wq.size() == 0, "R7", {tag, " writes outstanding"}, wq.size(), 0);
            end else begin
                if (poke && seen == 3) begin
                    start = 1'b1;
                    corr_cnt = 3'd1;
                    corr_pos = '0;
                    corr_pat = '1;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                seen++;
            end
        end
        start = 1'b0;
        if (!got) check(1'b0, "R8", {tag, " no done"}, 0, 1);
        @(negedge clk);
        check(!done && !busy, "R8", {tag, " single done pulse"}, int'(done), 0);
        wq.delete();
    endtask

    task automatic compare_mem(input string tag);
        int bad_d, bad_s;
        bad_d = 0;
        bad_s = 0;
        for (int i = 0; i < DB; i++) if (int'(dmem[i]) != exp_d[i]) bad_d++;
        for (int i = 0; i < SB; i++) if (int'(smem[i]) != exp_s[i]) bad_s++;
        check(bad_d == 0, tag, "data buffer mismatches", bad_d, 0);
        check(bad_s == 0, tag, "spare buffer mismatches", bad_s, 0);
    endtask

    initial begin
        for (int i = 0; i < DB; i++) begin
            dmem[i] = 8'((i * 7 + 3) & 255);
            exp_d[i] = (i * 7 + 3) & 255;
        end
        for (int i = 0; i < SB; i++) begin
            smem[i] = 8'((i * 13 + 5) & 255);
            exp_s[i] = (i * 13 + 5) & 255;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(!busy && !done && !fail && !mem_rd && !mem_wr, "R13", "reset state",
              {busy, done, fail, mem_rd, mem_wr}, 0);

        // R10 empty list
        run_case(0, '{5, 0, 0, 0}, '{12'hABC, 0, 0, 0}, "R10", 1'b0);
        // R3 odd position in data
        run_case(1, '{5, 0, 0, 0}, '{12'hABC, 0, 0, 0}, "R3", 1'b0);
        // R4 even position in data
        run_case(1, '{10, 0, 0, 0}, '{12'h5A3, 0, 0, 0}, "R4", 1'b0);
        // R2 position 0 accepted, then rejected with a wide pattern
        run_case(1, '{0, 0, 0, 0}, '{12'h07E, 0, 0, 0}, "R2", 1'b0);
        run_case(2, '{0, 0, 0, 0}, '{12'h011, 12'h1FF, 0, 0}, "R2", 1'b0);
        // R5 boundary symbol
        run_case(1, '{1365, 0, 0, 0}, '{12'h9D2, 0, 0, 0}, "R5", 1'b0);
        // R6 spare area, both parities and the last valid position
        run_case(3, '{1366, 1367, 1374, 0}, '{12'h3C4, 12'h8E1, 12'hF0F, 0}, "R6", 1'b0);
        // R7 order with a repeated position
        run_case(4, '{700, 33, 700, 0}, '{12'h123, 12'hFED, 12'h0F0, 12'h055}, "R7", 1'b0);
        // R1 out-of-range third entry stops the run
        run_case(4, '{2, 3, 1375, 4}, '{12'h111, 12'h222, 12'h333, 12'h444}, "R1", 1'b0);
        // R11 count above slot number
        run_case(7, '{100, 201, 0, 2047 / 2}, '{12'h0AA, 12'hBCD, 12'h0EE, 12'h777}, "R11", 1'b0);
        // R12 start while busy
        run_case(2, '{400, 401, 0, 0}, '{12'h456, 12'h789, 0, 0}, "R12", 1'b1);

        compare_mem("R7");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule